// File: doc/BRIEF.md
# Event Drain Back-Pressure Controller

This block keeps data from two consecutive events from interleaving in a bank of eight per-channel FIFOs. Each channel raises an end-of-trace strobe when its front-end source has delivered the last word of an event. From then on, that channel's wait-request toward its source is held high. Its source therefore stops pushing new words into the FIFO. The hold stays on until the whole bank has drained, meaning every FIFO reports empty in the same cycle. Between events, wait-request simply follows the FIFO's full flag.

The cycle in which the bank is found drained is called the drain event. It releases every hold. It also starts a completion pulse that is held high for a programmable number of cycles, at least two, so that a slower output clock domain can catch it. Each drain event adds one to a wrapping event counter. Because of this, the counter always equals the number of completion pulses seen since reset. The FIFOs and the sources lie outside the block; only their full, empty and end-of-trace flags enter it.

A three-state sequencer runs the block:

- IDLE: no event is open.
- DRAIN: at least one hold is set and the block waits for the bank to empty.
- STRETCH: the completion pulse is being driven.

The transitions are:

- IDLE to DRAIN on any end-of-trace.
- DRAIN to STRETCH on the drain event.
- STRETCH back to DRAIN when the stretch ends and a hold is set or an end-of-trace is present.
- STRETCH to IDLE otherwise.

Top module: `dbp_drain_ctrl`

## Requirements
- R1: A synchronous, active-high reset clears all holds, the event counter and the completion pulse. While the reset is applied and on the cycle after it, wait_req equals fifo_full.
- R2: For each channel i, wait_req[i] is the OR of fifo_full[i] and that channel's hold. A change on fifo_full shows on wait_req in the same cycle.
- R3: end_trace[i] high at a clock edge sets channel i's hold. wait_req[i] is then 1 from the next cycle, even with fifo_full[i] low, and it stays 1 while any bit of fifo_empty is 0.
- R4: In the DRAIN state, a cycle in which all eight fifo_empty bits are 1 is a drain event. All holds are clear in the following cycle, apart from the case in R6.
- R5: drain_pulse rises in the cycle after a drain event and stays high for exactly STRETCH cycles (default 2), then falls.
- R6: If end_trace[i] is high in the drain-event cycle, setting channel i's hold wins over clearing it. That hold stays set, and once the pulse ends a second drain event and a second pulse follow.
- R7: With the bank empty and no end-of-trace seen since the last drain event, drain_pulse stays 0 and the counter does not move.
- R8: event_count rises by exactly one at the edge where drain_pulse rises, and it changes at no other time except reset.
- R9: event_count is CNT_W bits wide (default 16). It wraps from all ones to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_full | input | NCH | Per-channel FIFO full flag |
| fifo_empty | input | NCH | Per-channel FIFO empty flag |
| end_trace | input | NCH | Per-channel end-of-trace strobe |
| wait_req | output | NCH | Per-channel wait-request to the source |
| drain_pulse | output | 1 | Stretched completion pulse |
| event_count | output | CNT_W | Count of drain events |

## Verification
The bench first confirms that a bank which is empty from the start produces no pulse when no end-of-trace has arrived. A design that fires on the plain all-empty level would pulse forever while idle. The bench also lands an end-of-trace on the same cycle as a drain event. A design that lets the clear win would drop that channel's hold, lose the second event and leave the count one short. It measures the pulse width edge by edge, which catches an off-by-one in the stretch timer. It drives the counter through its wrap with a narrowed width, and it checks that a full flag alone raises wait-request while the hold is clear.

// File: rtl/dbp_pkg.sv
package dbp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_STRETCH = 2'd2
    } dbp_state_e;

endpackage

// File: rtl/dbp_flag_bank.sv
// Per-channel hold flags: set by end-of-trace, cleared by a drain event.
// A set in the same cycle as the clear wins.
module dbp_flag_bank #(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] set_vec,
    input  logic           clr_all,
    output logic [NCH-1:0] hold
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) begin
                hold[g] <= 1'b0;
            end else if (set_vec[g]) begin
                hold[g] <= 1'b1;
            end else if (clr_all) begin
                hold[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dbp_seq.sv
// Drain sequencer: detects the drain event and stretches the completion pulse.
module dbp_seq
    import dbp_pkg::*;
#(
    parameter int STRETCH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic any_eot,
    input  logic any_hold,
    input  logic all_empty,
    output logic fire,
    output logic pulse
);

    localparam int SW = (STRETCH > 1) ? $clog2(STRETCH) : 1;
    localparam logic [SW-1:0] LOAD = SW'(STRETCH - 1);

    dbp_state_e      state_q, state_d;
    logic [SW-1:0]   cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_eot) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (all_empty) begin
                    state_d = ST_STRETCH;
                    cnt_d   = LOAD;
                end
            end
            ST_STRETCH: begin
                if (cnt_q == '0) begin
                    state_d = (any_hold || any_eot) ? ST_DRAIN : ST_IDLE;
                end else begin
                    cnt_d = cnt_q - SW'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        fire  = (state_q == ST_DRAIN) && all_empty;
        pulse = (state_q == ST_STRETCH);
    end

endmodule

// File: rtl/dbp_evt_cnt.sv
// Wrapping event counter.
module dbp_evt_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dbp_drain_ctrl.sv
module dbp_drain_ctrl #(
    parameter int NCH     = 8,
    parameter int CNT_W   = 16,
    parameter int STRETCH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   fifo_full,
    input  logic [NCH-1:0]   fifo_empty,
    input  logic [NCH-1:0]   end_trace,
    output logic [NCH-1:0]   wait_req,
    output logic             drain_pulse,
    output logic [CNT_W-1:0] event_count
);

    logic [NCH-1:0] hold;
    logic           fire;
    logic           all_empty;
    logic           any_eot;
    logic           any_hold;

    assign all_empty = &fifo_empty;
    assign any_eot   = |end_trace;
    assign any_hold  = |hold;

    dbp_flag_bank #(.NCH(NCH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_vec (end_trace),
        .clr_all (fire),
        .hold    (hold)
    );

    dbp_seq #(.STRETCH(STRETCH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .any_eot   (any_eot),
        .any_hold  (any_hold),
        .all_empty (all_empty),
        .fire      (fire),
        .pulse     (drain_pulse)
    );

    dbp_evt_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (fire),
        .count (event_count)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_wr
        assign wait_req[g] = fifo_full[g] | hold[g];
    end

endmodule

// File: rtl/dbp_drain_chk.sv
module dbp_drain_chk #(
    parameter int NCH   = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [NCH-1:0]   fifo_full,
    input logic [NCH-1:0]   fifo_empty,
    input logic [NCH-1:0]   end_trace,
    input logic [NCH-1:0]   wait_req,
    input logic             drain_pulse,
    input logic [CNT_W-1:0] event_count
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (event_count == '0) && !drain_pulse);

    assert_full_waits_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_full & ~wait_req) == '0);

    assert_eot_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (|end_trace) |=> ((wait_req & $past(end_trace)) == $past(end_trace)));

    assert_pulse_after_empty_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_pulse) |-> $past(&fifo_empty));

    assert_pulse_min_width_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_pulse) |=> drain_pulse);

    assert_count_on_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(drain_pulse) |-> event_count == CNT_W'($past(event_count) + 1'b1));

    assert_count_steady_R8: assert property (@(posedge clk) disable iff (rst)
        !$rose(drain_pulse) |-> $stable(event_count));

endmodule

bind dbp_drain_ctrl dbp_drain_chk #(.NCH(NCH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_dbp_drain_ctrl.sv
module sim_dbp_drain_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int CW  = 4;   // narrowed counter so the wrap is reachable

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] fifo_full  = '0;
    logic [NCH-1:0] fifo_empty = '1;
    logic [NCH-1:0] end_trace  = '0;
    logic [NCH-1:0] wait_req;
    logic           drain_pulse;
    logic [CW-1:0]  event_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    int exp_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbp_drain_ctrl #(.NCH(NCH), .CNT_W(CW), .STRETCH(2)) u0 (
        .clk, .rst, .fifo_full, .fifo_empty, .end_trace,
        .wait_req, .drain_pulse, .event_count
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, act, exp);
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // R1
    task automatic t_reset();
        rst = 1'b1; fifo_full = 8'h3C; end_trace = '0; fifo_empty = '1;
        nxt(); nxt();
        rst = 1'b0;
        nxt();
        chk_eq("R1 count", 32'(event_count), 0);
        chk_eq("R1 pulse", 32'(drain_pulse), 0);
        chk_eq("R1 wait_req", 32'(wait_req), 32'h3C);
        fifo_full = '0;
        exp_cnt = 0;
    endtask

    // R7
    task automatic t_idle();
        for (int k = 0; k < 6; k++) begin
            nxt();
            chk_eq("R7 idle pulse", 32'(drain_pulse), 0);
        end
        chk_eq("R7 idle count", 32'(event_count), 32'(exp_cnt));
    endtask

    // R2
    task automatic t_full();
        fifo_full = 8'hA5; #1;
        chk_eq("R2 full only", 32'(wait_req), 32'hA5);
        fifo_full = 8'h00; #1;
        chk_eq("R2 full cleared", 32'(wait_req), 0);
        nxt();
    endtask

    // R3 R4 R5 R8 R2
    task automatic t_basic();
        end_trace = 8'h08; fifo_empty = 8'hF7;
        nxt();
        end_trace = '0;
        chk_eq("R3 hold set", 32'(wait_req), 32'h08);
        fifo_full = 8'h40; #1;
        chk_eq("R2 full OR hold", 32'(wait_req), 32'h48);
        fifo_full = '0;
        for (int k = 0; k < 4; k++) begin
            nxt();
            chk_eq("R3 hold kept", 32'(wait_req), 32'h08);
            chk_eq("R4 no early pulse", 32'(drain_pulse), 0);
        end
        fifo_empty = 8'hFE;  // another channel still busy
        nxt();
        chk_eq("R3 hold while ch0 busy", 32'(wait_req), 32'h08);
        fifo_empty = '1;
        nxt();
        exp_cnt++;
        chk_eq("R4 holds cleared", 32'(wait_req), 0);
        chk_eq("R5 pulse cycle1", 32'(drain_pulse), 1);
        chk_eq("R8 count step", 32'(event_count), 32'(exp_cnt));
        nxt();
        chk_eq("R5 pulse cycle2", 32'(drain_pulse), 1);
        chk_eq("R8 count held", 32'(event_count), 32'(exp_cnt));
        nxt();
        chk_eq("R5 pulse fall", 32'(drain_pulse), 0);
        nxt();
        chk_eq("R7 no repulse", 32'(drain_pulse), 0);
    endtask

    // R6
    task automatic t_coincide();
        end_trace = 8'h20; fifo_empty = 8'hDF;
        nxt();
        end_trace = 8'h04; fifo_empty = '1;   // drain event plus new end-of-trace
        nxt();
        end_trace = '0;
        exp_cnt++;
        chk_eq("R6 set wins", 32'(wait_req), 32'h04);
        chk_eq("R6 first pulse", 32'(drain_pulse), 1);
        chk_eq("R6 first count", 32'(event_count), 32'(exp_cnt));
        nxt();
        chk_eq("R6 pulse hold", 32'(drain_pulse), 1);
        nxt();
        chk_eq("R6 gap", 32'(drain_pulse), 0);
        chk_eq("R6 hold survives", 32'(wait_req), 32'h04);
        nxt();
        exp_cnt++;
        chk_eq("R6 second pulse", 32'(drain_pulse), 1);
        chk_eq("R6 second count", 32'(event_count), 32'(exp_cnt));
        chk_eq("R6 hold released", 32'(wait_req), 0);
        nxt(); nxt();
    endtask

    task automatic one_event(input int ch);
        end_trace = NCH'(1) << ch;
        nxt();
        end_trace = '0;
        nxt();
        nxt(); nxt(); nxt();
        exp_cnt = (exp_cnt + 1) % (1 << CW);
    endtask

    // R9
    task automatic t_wrap();
        while (exp_cnt != (1 << CW) - 1) one_event(exp_cnt % NCH);
        chk_eq("R9 at max", 32'(event_count), 32'((1 << CW) - 1));
        one_event(1);
        chk_eq("R9 wrapped", 32'(event_count), 0);
    endtask

    initial begin
        nxt();
        t_reset();
        t_idle();
        t_full();
        t_basic();
        t_coincide();
        t_idle();
        t_wrap();
        t_reset();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule